// File: doc/BRIEF.md
# Supply Start-Up and Restart Sequencer

This block decides when the high-voltage start-up current source may charge the supply capacitor and when the rest of the controller may run. Its inputs are the outputs of analog comparators on the supply rail, which are read as digital flags. There are four supply levels: turn-on, turn-off, recharge (rearm) and protection floor. The block also takes a flag that says the drain is above the minimum start level, a flag that marks the power switch off-time, and a protection-trip input. It drives a charger enable and a run enable, and it reports its state.

At power-up the charger fills the supply capacitor until the turn-on level is reached. The controller then runs and the charger switches off. While the controller runs, a sag below the rearm level lets the charger top up the supply, but only during switch off-time. It keeps doing so until the turn-on level is reached again. A fall below the turn-off level stops the run and holds the gate low. A protection trip locks the charger out until the supply has decayed below the protection floor. When the drain is low the charger never starts, so the block does not retry while the input is powering down.

Top module: `ssr_supply_seq`

## Requirements
- R1: In state OFF (code 0) the charger is off. OFF moves to CHARGING (code 1) when the drain flag is high. The charger is never enabled while the synchronised drain flag is low, and CHARGING falls back to OFF when that flag drops.
- R2: CHARGING drives the charger enable high and run enable low. When the turn-on flag is high it moves to RUN (code 2), where run enable is high and the charger is off.
- R3: RUN moves to RECHARGE (code 2'd3, state code 3) when the rearm flag is low. In RECHARGE run enable stays high, and the charger is enabled only while both the off-time flag and the drain flag are high.
- R4: RECHARGE returns to RUN when the turn-on flag is high again.
- R5: In RUN or RECHARGE, a low turn-off flag sends the state to OFF and drops run enable. This takes priority over a protection trip that arrives in the same cycle, so that crossing clears the trip.
- R6: A protection trip in CHARGING, RUN or RECHARGE enters FAULT_WAIT (code 4). There both enables are low whatever the drain, turn-on and off-time flags do.
- R7: FAULT_WAIT leaves, to OFF, only when the protection-floor flag is low.
- R8: A protection trip seen in OFF has no effect: the state follows the drain flag alone.
- R9: Every flag passes through two synchronising flops. A flag change made between edges reaches the state after the third rising edge, and reaches the charger enable through the off-time or drain gating after the second rising edge.
- R10: An active-low reset drives the state to OFF (code 0) with both enables low. After reset is released, the block ignores its flags for two further edges while the internal reset synchroniser releases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released through a synchroniser |
| vcc_ge_on | input | 1 | Supply at or above the turn-on level |
| vcc_ge_off | input | 1 | Supply at or above the turn-off level |
| vcc_ge_rearm | input | 1 | Supply at or above the recharge level |
| vcc_ge_floor | input | 1 | Supply at or above the protection floor |
| hv_avail | input | 1 | Drain above the minimum start level |
| sw_off | input | 1 | Power switch is in its off-time |
| prot_trip | input | 1 | Protection trip request |
| hv_charge_en | output | 1 | Enable for the start-up current source |
| run_en | output | 1 | Enable for the controller; low holds the gate off |
| seq_state | output | 3 | State code: 0 OFF, 1 CHARGING, 2 RUN, 3 RECHARGE, 4 FAULT_WAIT |

## Verification
Flag edits become visible to the state after three rising edges: two synchroniser stages and then the state register. The off-time and drain gating of the charger enable appears after two edges. The bench changes its inputs on falling edges and updates its reference model on rising edges, using inputs delayed by the same two stages. It compares all three outputs on every falling edge, so each result is checked in exactly the cycle it is due. The two edges of reset-release hold-off are modelled with a separate count, so the first post-reset transitions are checked in the correct cycle too.

// File: rtl/ssr_pkg.sv
package ssr_pkg;

  typedef enum logic [2:0] {
    ST_OFF      = 3'd0,
    ST_CHARGE   = 3'd1,
    ST_RUN      = 3'd2,
    ST_RECHARGE = 3'd3,
    ST_FAULT    = 3'd4
  } seq_state_e;

  typedef struct packed {
    logic trip;
    logic sw_off;
    logic drain_ok;
    logic above_floor;
    logic above_rearm;
    logic above_off;
    logic above_on;
  } flags_t;

  localparam int unsigned FLAG_W = $bits(flags_t);

endpackage

// File: rtl/ssr_rst_sync.sv
module ssr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain <= '0;
    end else begin
      chain <= {chain[STAGES-2:0], 1'b1};
    end
  end

  assign srst_n = chain[STAGES-1];

endmodule

// File: rtl/ssr_flag_sync.sv
module ssr_flag_sync #(
  parameter int unsigned WIDTH  = 7,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [WIDTH-1:0] src;
    if (g == 0) begin : g_first
      assign src = din;
    end else begin : g_next
      assign src = stg[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg[g] <= '0;
      end else begin
        stg[g] <= src;
      end
    end
  end

  assign dout = stg[STAGES-1];

endmodule

// File: rtl/ssr_fsm.sv
module ssr_fsm
  import ssr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  flags_t     flg,
  output seq_state_e state_o,
  output logic       charge_en_o,
  output logic       run_en_o
);

  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OFF: begin
        if (flg.drain_ok) state_d = ST_CHARGE;
      end
      ST_CHARGE: begin
        if (!flg.drain_ok)     state_d = ST_OFF;
        else if (flg.trip)     state_d = ST_FAULT;
        else if (flg.above_on) state_d = ST_RUN;
      end
      ST_RUN: begin
        if (!flg.above_off)        state_d = ST_OFF;
        else if (flg.trip)         state_d = ST_FAULT;
        else if (!flg.above_rearm) state_d = ST_RECHARGE;
      end
      ST_RECHARGE: begin
        if (!flg.above_off)    state_d = ST_OFF;
        else if (flg.trip)     state_d = ST_FAULT;
        else if (flg.above_on) state_d = ST_RUN;
      end
      ST_FAULT: begin
        if (!flg.above_floor) state_d = ST_OFF;
      end
      default: state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
    end else begin
      state_q <= state_d;
    end
  end

  logic in_run, top_up;

  always_comb begin
    in_run = (state_q == ST_RUN) || (state_q == ST_RECHARGE);
    top_up = (state_q == ST_RECHARGE) && flg.sw_off;
    charge_en_o = flg.drain_ok && ((state_q == ST_CHARGE) || top_up);
    run_en_o    = in_run;
    state_o     = state_q;
  end

endmodule

// File: rtl/ssr_supply_seq.sv
module ssr_supply_seq
  import ssr_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vcc_ge_on,
  input  logic       vcc_ge_off,
  input  logic       vcc_ge_rearm,
  input  logic       vcc_ge_floor,
  input  logic       hv_avail,
  input  logic       sw_off,
  input  logic       prot_trip,
  output logic       hv_charge_en,
  output logic       run_en,
  output logic [2:0] seq_state
);

  logic              rst_n_s;
  logic [FLAG_W-1:0] flg_raw, flg_vec;
  flags_t            flg_s;
  seq_state_e        st;

  ssr_rst_sync #(.STAGES(RST_STAGES)) rst_sync_i (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_n_s)
  );

  assign flg_raw = {prot_trip, sw_off, hv_avail, vcc_ge_floor,
                    vcc_ge_rearm, vcc_ge_off, vcc_ge_on};

  ssr_flag_sync #(.WIDTH(FLAG_W), .STAGES(SYNC_STAGES)) flag_sync_i (
    .clk   (clk),
    .rst_n (rst_n_s),
    .din   (flg_raw),
    .dout  (flg_vec)
  );

  assign flg_s = flags_t'(flg_vec);

  ssr_fsm fsm_i (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .flg         (flg_s),
    .state_o     (st),
    .charge_en_o (hv_charge_en),
    .run_en_o    (run_en)
  );

  assign seq_state = st;

endmodule

// File: rtl/ssr_supply_seq_chk.sv
module ssr_supply_seq_chk
  import ssr_pkg::*;
(
  input logic       clk,
  input logic       rst_n_s,
  input flags_t     flg_s,
  input logic       hv_charge_en,
  input logic       run_en,
  input logic [2:0] seq_state
);

  a_r1_charge_needs_drain: assert property (@(posedge clk) disable iff (!rst_n_s)
    hv_charge_en |-> flg_s.drain_ok);

  a_r2_start_to_run: assert property (@(posedge clk) disable iff (!rst_n_s)
    (seq_state == 3'd1 && flg_s.drain_ok && !flg_s.trip && flg_s.above_on)
      |=> (run_en && !hv_charge_en));

  a_r3_topup_in_offtime: assert property (@(posedge clk) disable iff (!rst_n_s)
    (run_en && hv_charge_en) |-> flg_s.sw_off);

  a_r5_uvlo_stops_run: assert property (@(posedge clk) disable iff (!rst_n_s)
    (run_en && !flg_s.above_off) |=> !run_en);

  a_r6_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n_s)
    (seq_state == 3'd4) |-> (!hv_charge_en && !run_en));

  a_r7_fault_holds: assert property (@(posedge clk) disable iff (!rst_n_s)
    (seq_state == 3'd4 && flg_s.above_floor) |=> (seq_state == 3'd4));

  a_r8_trip_ignored_off: assert property (@(posedge clk) disable iff (!rst_n_s)
    (seq_state == 3'd0 && !flg_s.drain_ok) |=> (seq_state == 3'd0));

endmodule

bind ssr_supply_seq ssr_supply_seq_chk chk_i (
  .clk          (clk),
  .rst_n_s      (rst_n_s),
  .flg_s        (flg_s),
  .hv_charge_en (hv_charge_en),
  .run_en       (run_en),
  .seq_state    (seq_state)
);

// File: tb/ssr_supply_seq_tb.sv
module ssr_supply_seq_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic on_f = 0, off_f = 0, rearm_f = 0, floor_f = 0, drn_f = 0, swo_f = 0, trip_f = 0;
  logic hv_charge_en, run_en;
  logic [2:0] seq_state;

  always #4 clk = ~clk;

  ssr_supply_seq dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .vcc_ge_on    (on_f),
    .vcc_ge_off   (off_f),
    .vcc_ge_rearm (rearm_f),
    .vcc_ge_floor (floor_f),
    .hv_avail     (drn_f),
    .sw_off       (swo_f),
    .prot_trip    (trip_f),
    .hv_charge_en (hv_charge_en),
    .run_en       (run_en),
    .seq_state    (seq_state)
  );

  int n_chk = 0, n_fail = 0, cycles = 0;
  string cur_req = "R10";
  bit done = 0;

  // reference model: bit order {trip, swoff, drain, floor, rearm, off, on}
  int m_st = 0;
  bit [6:0] m_q1 = '0, m_q2 = '0;
  int m_rc = 0;

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_st = 0; m_q1 = '0; m_q2 = '0; m_rc = 0;
    end else begin
      if (m_rc >= 2) begin
        int nx;
        nx = m_st;
        case (m_st)
          0: if (m_q2[4]) nx = 1;
          1: if (!m_q2[4]) nx = 0; else if (m_q2[6]) nx = 4; else if (m_q2[0]) nx = 2;
          2: if (!m_q2[1]) nx = 0; else if (m_q2[6]) nx = 4; else if (!m_q2[2]) nx = 3;
          3: if (!m_q2[1]) nx = 0; else if (m_q2[6]) nx = 4; else if (m_q2[0]) nx = 2;
          4: if (!m_q2[3]) nx = 0;
          default: nx = 0;
        endcase
        m_st = nx;
        m_q2 = m_q1;
        m_q1 = {trip_f, swo_f, drn_f, floor_f, rearm_f, off_f, on_f};
      end
      if (m_rc < 2) m_rc++;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      bit erun, echg;
      erun = (m_st == 2) || (m_st == 3);
      echg = m_q2[4] && ((m_st == 1) || (m_st == 3 && m_q2[5]));
      n_chk++;
      if (seq_state !== 3'(m_st) || run_en !== erun || hv_charge_en !== echg) begin
        n_fail++;
        $display("FAIL %s: state/run/chg actual %0d/%0b/%0b expected %0d/%0b/%0b at cycle %0d",
                 cur_req, seq_state, run_en, hv_charge_en, m_st, erun, echg, cycles);
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_vcc(input bit on, input bit off, input bit rearm, input bit fl);
    on_f = on; off_f = off; rearm_f = rearm; floor_f = fl;
  endtask

  // explicit latency probe on the state output, in addition to the model
  task automatic expect_state(input int v, input string req);
    n_chk++;
    if (seq_state !== 3'(v)) begin
      n_fail++;
      $display("FAIL %s: state actual %0d expected %0d", req, seq_state, v);
    end
  endtask

  initial begin
    // R10: reset state, and hold-off after release
    cur_req = "R10";
    drn_f = 1;
    idle(3);
    expect_state(0, "R10");
    rst_n = 1;
    idle(1);
    expect_state(0, "R10");
    idle(8);

    // R1: drain low drops charger and returns to OFF
    cur_req = "R1";
    drn_f = 0;
    idle(6);
    expect_state(0, "R1");

    // R8: trip in OFF ignored
    cur_req = "R8";
    trip_f = 1;
    idle(6);
    expect_state(0, "R8");
    trip_f = 0;
    idle(4);

    // R9: latency of drain flag to state
    cur_req = "R9";
    drn_f = 1;
    idle(2);
    expect_state(0, "R9");
    idle(1);
    expect_state(1, "R9");
    idle(4);

    // R2: reach turn-on level
    cur_req = "R2";
    set_vcc(1, 1, 1, 1);
    idle(6);
    expect_state(2, "R2");

    // R3: sag below rearm, charge only in off-time
    cur_req = "R3";
    set_vcc(0, 1, 0, 1);
    idle(5);
    for (int i = 0; i < 12; i++) begin
      swo_f = (i % 3 != 0);
      idle(1);
    end
    drn_f = 0;
    swo_f = 1;
    idle(5);
    drn_f = 1;
    idle(4);
    swo_f = 0;

    // R4: back to turn-on level
    cur_req = "R4";
    set_vcc(1, 1, 1, 1);
    idle(6);
    expect_state(2, "R4");

    // R5: fall below turn-off, with simultaneous trip
    cur_req = "R5";
    set_vcc(0, 0, 0, 1);
    trip_f = 1;
    idle(1);
    trip_f = 0;
    idle(3);
    expect_state(1, "R5");
    set_vcc(1, 1, 1, 1);
    idle(6);

    // R6: trip from RUN, flags wiggle in fault
    cur_req = "R6";
    trip_f = 1;
    idle(1);
    trip_f = 0;
    for (int i = 0; i < 10; i++) begin
      swo_f = i[0];
      on_f = i[1];
      idle(1);
    end
    expect_state(4, "R6");

    // R7: leave fault only below floor
    cur_req = "R7";
    set_vcc(0, 0, 0, 1);
    idle(8);
    expect_state(4, "R7");
    floor_f = 0;
    idle(6);

    // R9: pseudo-random flag patterns
    cur_req = "R9";
    begin
      bit [15:0] lf = 16'hACE1;
      for (int i = 0; i < 400; i++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        {trip_f, swo_f, drn_f, floor_f, rearm_f, off_f, on_f} = lf[6:0] & {(lf[9:8] == 2'b00), 6'h3F};
        idle(1 + lf[11]);
      end
    end
    idle(4);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  always @(posedge clk) begin
    if (cycles > 20000 && !done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule